// File: doc/BRIEF.md
# Accumulator ALU with Arithmetic Flags

This block is the datapath arithmetic unit of a small 8-bit accumulator machine. Each cycle in which `valid_i` is high, it takes an operation code, the accumulator, a second operand byte, the B register and the current carry, auxiliary-carry and overflow flags. It computes the new accumulator, the new B register and the three updated flags. The results are captured in output registers at the next rising clock edge and held there until the next valid operation.

The operation set covers 8-bit addition with and without carry-in, subtraction with borrow, increment, decrement, an unsigned 8x8 multiply that splits its product across two registers, unsigned divide with a zero-divisor indication, packed-BCD decimal adjust, bitwise AND/OR/XOR, complement, clear, four rotate forms and nibble swap. Decoding, operand fetch and every status bit other than the three flags belong to the surrounding core. Each operation either changes a flag or passes it through from its input unchanged.

Top module: `acc_alu`

## Requirements
- R1: Op 0 (add) and op 1 (add with carry-in `cy_i`) write A+operand(+C) to the accumulator. C is the carry out of bit 7, AC is the carry out of bit 3, and OV is the XOR of the carries out of bits 6 and 7.
- R2: Op 2 (subtract with borrow) writes A-operand-C. C is set on a borrow out of bit 7 and AC on a borrow out of bit 3. OV flags signed overflow, which is the XOR of the internal carries out of bits 6 and 7 of A+~operand+~C.
- R3: Op 3 (increment) and op 4 (decrement) wrap modulo 256 and leave C, AC and OV equal to their inputs.
- R4: Op 5 (multiply) writes the low byte of A*B to the accumulator and the high byte to B. It clears C, sets OV when the product exceeds FFh, and keeps AC.
- R5: Op 6 (divide) writes the quotient of A/B to the accumulator and the remainder to B, clears C and OV, and keeps AC. When B is zero, it leaves A and B at their inputs, sets OV and clears C.
- R6: Op 7 (decimal adjust) adds 06h when the low nibble exceeds 9 or AC is set. It then adds 60h when the high nibble exceeds 9 or C is set (or became set). C is set on a carry out of either step and is never cleared. AC and OV are kept.
- R7: Ops 8 (AND operand), 9 (OR operand), 10 (XOR operand), 11 (complement) and 12 (clear to 00h) leave all three flags at their inputs.
- R8: Op 13 rotates left and op 14 rotates right without carry. Op 15 rotates left through C (bit 7 to C, C to bit 0). Op 16 rotates right through C (bit 0 to C, C to bit 7). Op 17 swaps the nibbles. Only ops 15 and 16 change C. AC and OV are kept.
- R9: Every operation other than multiply and divide passes `breg_i` to `breg_o` unchanged.
- R10: Results appear on the outputs at the first rising edge on which `valid_i` is high. The outputs hold their values while `valid_i` is low.
- R11: While `rst_ni` is low, all outputs are zero.
- R12: Operation codes 18 to 31 pass the accumulator, B and all flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Execute the presented operation this cycle |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Current accumulator |
| opnd_i | input | 8 | Second operand byte |
| breg_i | input | 8 | Current B register |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| ov_i | input | 1 | Current overflow flag |
| acc_o | output | 8 | New accumulator |
| breg_o | output | 8 | New B register |
| cy_o | output | 1 | New carry flag |
| ac_o | output | 1 | New auxiliary-carry flag |
| ov_o | output | 1 | New overflow flag |

## Verification
The data width is fixed at 8 bits by the shared package, so the bench builds the block with its only configuration. At that width the bench can set exact byte patterns for the flag corners: carry out of bit 3 without bit 7, signed overflow in both directions, the FFh x FFh product and a zero divisor. It also covers decimal-adjust cases where the high-nibble correction is forced either by the nibble value or by an incoming carry.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW      = 8;
  localparam int NW      = DW / 2;
  localparam int OPW     = 5;
  localparam int BCD_MAX = 9;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_MUL  = 5'd5,
    OP_DIV  = 5'd6,
    OP_DA   = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_CPL  = 5'd11,
    OP_CLR  = 5'd12,
    OP_RL   = 5'd13,
    OP_RR   = 5'd14,
    OP_RLC  = 5'd15,
    OP_RRC  = 5'd16,
    OP_SWAP = 5'd17
  } op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          ac_o,
  output logic          ov_o
);
  logic [DW-1:0] bx;
  logic          cx;
  logic [NW:0]   lo_sum;
  logic [DW-1:0] mid_sum;
  logic [DW:0]   full_sum;
  logic          c3, c6, c7;

  // subtract as A + ~B + ~borrow; carries invert back into borrows
  assign bx = sub_i ? ~b_i : b_i;
  assign cx = sub_i ? ~cin_i : cin_i;

  assign lo_sum   = {1'b0, a_i[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, cx};
  assign mid_sum  = {1'b0, a_i[DW-2:0]} + {1'b0, bx[DW-2:0]} + {{(DW-1){1'b0}}, cx};
  assign full_sum = {1'b0, a_i} + {1'b0, bx} + {{DW{1'b0}}, cx};

  assign c3 = lo_sum[NW];
  assign c6 = mid_sum[DW-1];
  assign c7 = full_sum[DW];

  assign res_o = full_sum[DW-1:0];
  assign cy_o  = sub_i ? ~c7 : c7;
  assign ac_o  = sub_i ? ~c3 : c3;
  assign ov_o  = c6 ^ c7;
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] mul_lo_o,
  output logic [DW-1:0] mul_hi_o,
  output logic          mul_ov_o,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o,
  output logic          div_zero_o
);
  logic [2*DW-1:0] prod;

  assign prod     = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
  assign mul_lo_o = prod[DW-1:0];
  assign mul_hi_o = prod[2*DW-1:DW];
  assign mul_ov_o = |prod[2*DW-1:DW];

  assign div_zero_o = (b_i == '0);
  // zero divisor: hand back the operands untouched
  assign quo_o = div_zero_o ? a_i : a_i / b_i;
  assign rem_o = div_zero_o ? b_i : a_i % b_i;
endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic          cy_i,
  input  logic          ac_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o
);
  localparam logic [DW:0] LO_FIX = (DW+1)'(6);
  localparam logic [DW:0] HI_FIX = (DW+1)'(6) << NW;

  logic          lo_big, hi_big, cy_mid;
  logic [DW:0]   s1, s2;

  assign lo_big = (a_i[NW-1:0] > NW'(BCD_MAX)) || ac_i;
  assign s1     = lo_big ? ({1'b0, a_i} + LO_FIX) : {1'b0, a_i};
  assign cy_mid = cy_i | s1[DW];
  assign hi_big = (s1[DW-1:NW] > NW'(BCD_MAX)) || cy_mid;
  assign s2     = hi_big ? ({1'b0, s1[DW-1:0]} + HI_FIX) : {1'b0, s1[DW-1:0]};

  assign res_o = s2[DW-1:0];
  assign cy_o  = cy_mid | s2[DW];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
(
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_CPL:  res_o = ~a_i;
      OP_CLR:  res_o = '0;
      OP_RL:   res_o = {a_i[DW-2:0], a_i[DW-1]};
      OP_RR:   res_o = {a_i[0], a_i[DW-1:1]};
      OP_RLC: begin
        res_o = {a_i[DW-2:0], cy_i};
        cy_o  = a_i[DW-1];
      end
      OP_RRC: begin
        res_o = {cy_i, a_i[DW-1:1]};
        cy_o  = a_i[0];
      end
      OP_SWAP: res_o = {a_i[NW-1:0], a_i[DW-1:NW]};
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opnd_i,
  input  logic [DW-1:0]  breg_i,
  input  logic           cy_i,
  input  logic           ac_i,
  input  logic           ov_i,
  output logic [DW-1:0]  acc_o,
  output logic [DW-1:0]  breg_o,
  output logic           cy_o,
  output logic           ac_o,
  output logic           ov_o
);
  op_e op;
  assign op = op_e'(op_i);

  logic [DW-1:0] as_res;
  logic          as_cy, as_ac, as_ov, as_sub, as_cin;
  logic [DW-1:0] mul_lo, mul_hi, quo, rem;
  logic          mul_ov, div_zero;
  logic [DW-1:0] da_res, lg_res;
  logic          da_cy, lg_cy;

  assign as_sub = (op == OP_SUBB);
  assign as_cin = (op == OP_ADD) ? 1'b0 : cy_i;

  acc_alu_addsub u_addsub (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (as_cin),
    .sub_i (as_sub),
    .res_o (as_res),
    .cy_o  (as_cy),
    .ac_o  (as_ac),
    .ov_o  (as_ov)
  );

  acc_alu_muldiv u_muldiv (
    .a_i        (acc_i),
    .b_i        (breg_i),
    .mul_lo_o   (mul_lo),
    .mul_hi_o   (mul_hi),
    .mul_ov_o   (mul_ov),
    .quo_o      (quo),
    .rem_o      (rem),
    .div_zero_o (div_zero)
  );

  acc_alu_bcd u_bcd (
    .a_i   (acc_i),
    .cy_i  (cy_i),
    .ac_i  (ac_i),
    .res_o (da_res),
    .cy_o  (da_cy)
  );

  acc_alu_logic u_logic (
    .op_i  (op),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cy_i  (cy_i),
    .res_o (lg_res),
    .cy_o  (lg_cy)
  );

  logic [DW-1:0] n_acc, n_b;
  logic          n_cy, n_ac, n_ov;

  always_comb begin
    n_acc = acc_i;
    n_b   = breg_i;
    n_cy  = cy_i;
    n_ac  = ac_i;
    n_ov  = ov_i;
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        n_acc = as_res;
        n_cy  = as_cy;
        n_ac  = as_ac;
        n_ov  = as_ov;
      end
      OP_INC: n_acc = acc_i + DW'(1);
      OP_DEC: n_acc = acc_i - DW'(1);
      OP_MUL: begin
        n_acc = mul_lo;
        n_b   = mul_hi;
        n_cy  = 1'b0;
        n_ov  = mul_ov;
      end
      OP_DIV: begin
        n_acc = quo;
        n_b   = rem;
        n_cy  = 1'b0;
        n_ov  = div_zero;
      end
      OP_DA: begin
        n_acc = da_res;
        n_cy  = da_cy;
      end
      OP_AND, OP_OR, OP_XOR, OP_CPL, OP_CLR,
      OP_RL, OP_RR, OP_RLC, OP_RRC, OP_SWAP: begin
        n_acc = lg_res;
        n_cy  = lg_cy;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      breg_o <= '0;
      cy_o   <= 1'b0;
      ac_o   <= 1'b0;
      ov_o   <= 1'b0;
    end else if (valid_i) begin
      acc_o  <= n_acc;
      breg_o <= n_b;
      cy_o   <= n_cy;
      ac_o   <= n_ac;
      ov_o   <= n_ov;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [OPW-1:0] op_i,
  input logic [DW-1:0]  acc_i,
  input logic [DW-1:0]  breg_i,
  input logic           cy_i,
  input logic           ac_i,
  input logic           ov_i,
  input logic [DW-1:0]  acc_o,
  input logic [DW-1:0]  breg_o,
  input logic           cy_o,
  input logic           ac_o,
  input logic           ov_o
);
  // R3
  incdec_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_INC || op_i == OP_DEC) |=>
      cy_o == $past(cy_i) && ac_o == $past(ac_i) && ov_o == $past(ov_i));

  // R4
  mul_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_MUL |=>
      {breg_o, acc_o} == 16'($past(acc_i)) * 16'($past(breg_i)) && !cy_o);

  // R5
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_DIV && breg_i == '0 |=>
      ov_o && !cy_o && acc_o == $past(acc_i) && breg_o == $past(breg_i));

  // R8
  swap_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_SWAP |=>
      acc_o == {$past(acc_i[NW-1:0]), $past(acc_i[DW-1:NW])} && cy_o == $past(cy_i));

  // R9
  breg_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i != OP_MUL && op_i != OP_DIV |=> breg_o == $past(breg_i));

  // R10
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_o) && $stable(breg_o) && $stable(cy_o)
                 && $stable(ac_o) && $stable(ov_o));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .acc_i   (acc_i),
  .breg_i  (breg_i),
  .cy_i    (cy_i),
  .ac_i    (ac_i),
  .ov_i    (ov_i),
  .acc_o   (acc_o),
  .breg_o  (breg_o),
  .cy_o    (cy_o),
  .ac_o    (ac_o),
  .ov_o    (ov_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  import acc_alu_pkg::*;

  localparam int CLK_P = 10;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           valid_i = 1'b0;
  logic [OPW-1:0] op_i = '0;
  logic [DW-1:0]  acc_i = '0, opnd_i = '0, breg_i = '0;
  logic           cy_i = 1'b0, ac_i = 1'b0, ov_i = 1'b0;
  logic [DW-1:0]  acc_o, breg_o;
  logic           cy_o, ac_o, ov_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  acc_alu u_dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .acc_i, .opnd_i, .breg_i,
    .cy_i, .ac_i, .ov_i, .acc_o, .breg_o, .cy_o, .ac_o, .ov_o
  );

  task automatic chk(input string tag, input logic [7:0] ea, input logic [7:0] eb,
                     input logic ec, input logic eac, input logic eov);
    n_chk++;
    if ({acc_o, breg_o, cy_o, ac_o, ov_o} !== {ea, eb, ec, eac, eov}) begin
      n_fail++;
      $display("FAIL %s: got A=%h B=%h C=%b AC=%b OV=%b, exp A=%h B=%h C=%b AC=%b OV=%b",
               tag, acc_o, breg_o, cy_o, ac_o, ov_o, ea, eb, ec, eac, eov);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] d,
                       input logic [7:0] b, input logic c, input logic ac, input logic ov);
    @(negedge clk_i);
    op_i = op; acc_i = a; opnd_i = d; breg_i = b;
    cy_i = c; ac_i = ac; ov_i = ov; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 reset", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_add;
    apply(OP_ADD, 8'h3F, 8'hD3, 8'h55, 1'b1, 1'b0, 1'b0);
    chk("R1 add 3F+D3", 8'h12, 8'h55, 1'b1, 1'b1, 1'b0);
    apply(OP_ADD, 8'h7F, 8'h73, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R1 add signed ovf", 8'hF2, 8'h00, 1'b0, 1'b1, 1'b1);
    apply(OP_ADDC, 8'h3F, 8'hD3, 8'h11, 1'b1, 1'b0, 1'b1);
    chk("R1 addc 3F+D3+1", 8'h13, 8'h11, 1'b1, 1'b1, 1'b0);
    apply(OP_ADDC, 8'hFF, 8'h00, 8'h22, 1'b1, 1'b0, 1'b0);
    chk("R1 addc FF+0+1", 8'h00, 8'h22, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_subb;
    apply(OP_SUBB, 8'h50, 8'h4F, 8'h33, 1'b1, 1'b0, 1'b1);
    chk("R2 subb 50-4F-1", 8'h00, 8'h33, 1'b0, 1'b1, 1'b0);
    apply(OP_SUBB, 8'h80, 8'h01, 8'h44, 1'b0, 1'b0, 1'b0);
    chk("R2 subb signed ovf", 8'h7F, 8'h44, 1'b0, 1'b1, 1'b1);
    apply(OP_SUBB, 8'h10, 8'h20, 8'h00, 1'b0, 1'b1, 1'b1);
    chk("R2 subb borrow", 8'hF0, 8'h00, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_incdec;
    apply(OP_INC, 8'hFF, 8'h12, 8'h66, 1'b1, 1'b0, 1'b1);
    chk("R3 inc wrap", 8'h00, 8'h66, 1'b1, 1'b0, 1'b1);
    apply(OP_DEC, 8'h00, 8'h12, 8'h77, 1'b0, 1'b1, 1'b0);
    chk("R3 dec wrap", 8'hFF, 8'h77, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_mul;
    apply(OP_MUL, 8'hFF, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0);
    chk("R4 mul FFxFF", 8'h01, 8'hFE, 1'b0, 1'b1, 1'b1);
    apply(OP_MUL, 8'h0C, 8'h00, 8'h0A, 1'b1, 1'b0, 1'b1);
    chk("R4 mul small", 8'h78, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_div;
    apply(OP_DIV, 8'h64, 8'h00, 8'h07, 1'b1, 1'b1, 1'b1);
    chk("R5 div 100/7", 8'h0E, 8'h02, 1'b0, 1'b1, 1'b0);
    apply(OP_DIV, 8'h55, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R5 div by zero", 8'h55, 8'h00, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_da;
    apply(OP_DA, 8'h4C, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0);
    chk("R6 da low fix", 8'h52, 8'h01, 1'b0, 1'b0, 1'b0);
    apply(OP_DA, 8'h9A, 8'h00, 8'h02, 1'b0, 1'b0, 1'b1);
    chk("R6 da both carry", 8'h00, 8'h02, 1'b1, 1'b0, 1'b1);
    apply(OP_DA, 8'h61, 8'h00, 8'h03, 1'b0, 1'b1, 1'b0);
    chk("R6 da from ac", 8'h67, 8'h03, 1'b0, 1'b1, 1'b0);
    apply(OP_DA, 8'h12, 8'h00, 8'h04, 1'b1, 1'b0, 1'b0);
    chk("R6 da from carry", 8'h72, 8'h04, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_logic;
    apply(OP_AND, 8'hAC, 8'h0F, 8'h5A, 1'b1, 1'b1, 1'b1);
    chk("R7 and", 8'h0C, 8'h5A, 1'b1, 1'b1, 1'b1);
    apply(OP_OR, 8'hAC, 8'h0F, 8'h5A, 1'b0, 1'b1, 1'b0);
    chk("R7 or", 8'hAF, 8'h5A, 1'b0, 1'b1, 1'b0);
    apply(OP_XOR, 8'hAC, 8'h0F, 8'h5A, 1'b1, 1'b0, 1'b1);
    chk("R7 xor", 8'hA3, 8'h5A, 1'b1, 1'b0, 1'b1);
    apply(OP_CPL, 8'hAC, 8'h0F, 8'h5A, 1'b1, 1'b1, 1'b1);
    chk("R7 cpl", 8'h53, 8'h5A, 1'b1, 1'b1, 1'b1);
    apply(OP_CLR, 8'hAC, 8'h0F, 8'h5A, 1'b1, 1'b1, 1'b1);
    chk("R7 clr", 8'h00, 8'h5A, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_rotate;
    apply(OP_RL, 8'hF0, 8'h00, 8'h9C, 1'b0, 1'b1, 1'b1);
    chk("R8 rl", 8'hE1, 8'h9C, 1'b0, 1'b1, 1'b1);
    apply(OP_RR, 8'hF0, 8'h00, 8'h9C, 1'b1, 1'b0, 1'b0);
    chk("R8 rr", 8'h78, 8'h9C, 1'b1, 1'b0, 1'b0);
    apply(OP_RLC, 8'h3C, 8'h00, 8'h9C, 1'b1, 1'b1, 1'b0);
    chk("R8 rlc", 8'h79, 8'h9C, 1'b0, 1'b1, 1'b0);
    apply(OP_RRC, 8'hBD, 8'h00, 8'h9C, 1'b0, 1'b0, 1'b1);
    chk("R8 rrc", 8'h5E, 8'h9C, 1'b1, 1'b0, 1'b1);
    apply(OP_SWAP, 8'h72, 8'h00, 8'h9C, 1'b1, 1'b1, 1'b1);
    chk("R8 swap", 8'h27, 8'h9C, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_hold;
    apply(OP_ADD, 8'h01, 8'h02, 8'hA5, 1'b0, 1'b0, 1'b0);
    chk("R10 one-cycle result", 8'h03, 8'hA5, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    op_i = OP_MUL; acc_i = 8'hFF; breg_i = 8'hFF; cy_i = 1'b1; ac_i = 1'b1; ov_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10 hold while idle", 8'h03, 8'hA5, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_undef;
    apply(5'd18, 8'h3E, 8'h77, 8'hC4, 1'b1, 1'b0, 1'b1);
    chk("R12 undefined op 18", 8'h3E, 8'hC4, 1'b1, 1'b0, 1'b1);
    apply(5'd31, 8'h81, 8'h77, 8'h18, 1'b0, 1'b1, 1'b0);
    chk("R12 undefined op 31", 8'h81, 8'h18, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout, exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_add();
    t_subb();
    t_incdec();
    t_mul();
    t_div();
    t_da();
    t_logic();
    t_rotate();
    t_hold();
    t_undef();
    @(negedge clk_i);
    finish_run();
  end
endmodule